// File: doc/BRIEF.md
# HDLC Receive Byte FIFO with End-of-Packet Tags

This block buffers received bytes between a bit-level HDLC receiver and a host. Each stored entry holds a data byte and a 2-bit tag. A nonzero tag marks the final byte of a packet and says how that packet ended: on a good closing flag, on an abort sequence, or as an invalid frame. The receiver pushes entries through a write port. The host pops them from a show-ahead read port, where the head entry is always presented on `rd_data` and `rd_tag`.

The block keeps a fill level. It raises a level flag when the occupancy exceeds a programmable 7-bit threshold, and it signals when the head entry closes a packet. If the host reads while the FIFO is empty, the block returns zero and pulses an event. If the receiver writes into a full FIFO, the byte is dropped, an overflow event pulses and the receiver is locked out. The lockout lasts until the receiver reports the next flag. If the host has not made room by then, the next write overflows again.

Top module: `hdlc_rx_fifo`

## Requirements
- R1: After reset the level is 0, `rx_enabled` is 1, `last_next`, `above_thresh`, `overflow_evt` and `empty_rd_evt` are 0, and `rd_data`/`rd_tag` read 0.
- R2: Accepted bytes leave in the order they were written. The head entry is shown on `rd_data`/`rd_tag` in the cycle after the edge that wrote it into an empty FIFO. A read with `rd_en` high pops the head at the clock edge.
- R3: The tag is stored with its byte and returned unchanged. The encoding is 0 for a mid-packet byte, 1 for a packet closed by a flag, 2 for an aborted packet and 3 for an invalid packet.
- R4: `last_next` is 1 exactly when the FIFO is not empty and the head entry's tag is nonzero.
- R5: `level` counts the stored entries and can reach 128. A write and a non-empty read in the same cycle leave it unchanged.
- R6: `above_thresh` is 1 exactly when `level` is strictly greater than `full_thresh`.
- R7: A write with `rx_enabled` high while `level` is 128 is discarded. It makes `overflow_evt` high for one cycle after that edge and drives `rx_enabled` low from that edge. This holds even when a read happens in the same cycle.
- R8: While `rx_enabled` is 0, writes are ignored and raise no overflow event.
- R9: `flag_seen` while `rx_enabled` is 0 sets `rx_enabled` to 1 after the next edge. A later write into a still-full FIFO overflows again.
- R10: A read of an empty FIFO returns `rd_data` 0 and `rd_tag` 0 and leaves the contents and level unchanged. It pulses `empty_rd_evt` for the one cycle after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Receiver write request |
| wr_data | input | 8 | Byte to store |
| wr_tag | input | 2 | End-of-packet tag for the byte |
| flag_seen | input | 1 | Receiver detected a flag; clears the overflow lockout |
| rd_en | input | 1 | Host read (pop) request |
| full_thresh | input | 7 | Fill-level threshold |
| rd_data | output | 8 | Head byte, 0 when empty |
| rd_tag | output | 2 | Head tag, 0 when empty |
| level | output | 8 | Number of stored entries |
| above_thresh | output | 1 | Level exceeds threshold |
| last_next | output | 1 | Head entry ends a packet |
| rx_enabled | output | 1 | Receiver writes are being accepted |
| overflow_evt | output | 1 | One-cycle pulse after a write into a full FIFO |
| empty_rd_evt | output | 1 | One-cycle pulse after a read of an empty FIFO |

## Verification
The FIFO contents, `level` and `rx_enabled` change at the clock edge where their request is sampled. The two event pulses are registered, so each is high for the one cycle after that edge. `rd_data`, `rd_tag`, `last_next` and `above_thresh` are combinational from registered state, so they are valid from the same edge onward. The bench drives inputs on the falling edge and checks every result at the next falling edge, after exactly one rising edge. It checks the event pulses again one cycle later to confirm that they have fallen.

// File: rtl/hdlc_rx_fifo_pkg.sv
package hdlc_rx_fifo_pkg;
  typedef enum logic [1:0] {
    TAG_MID     = 2'd0,
    TAG_GOOD    = 2'd1,
    TAG_ABORT   = 2'd2,
    TAG_INVALID = 2'd3
  } eop_tag_e;

  typedef struct packed {
    eop_tag_e   tag;
    logic [7:0] data;
  } fifo_entry_t;
endpackage

// File: rtl/hdlc_rx_fifo_mem.sv
module hdlc_rx_fifo_mem
  import hdlc_rx_fifo_pkg::*;
#(
  parameter int DEPTH = 128,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic        clk,
  input  logic        we,
  input  logic [AW-1:0] waddr,
  input  fifo_entry_t wentry,
  input  logic [AW-1:0] raddr,
  output fifo_entry_t rentry
);
  fifo_entry_t store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wentry;
  end

  assign rentry = store[raddr];
endmodule

// File: rtl/hdlc_rx_ovf_lock.sv
module hdlc_rx_ovf_lock (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_req,
  input  logic full,
  input  logic flag_seen,
  output logic wr_accept,
  output logic rx_enabled,
  output logic overflow_evt
);
  logic en_q, en_d, ovf_q, ovf_d;
  logic ovf_hit;

  assign ovf_hit   = wr_req && en_q && full;
  assign wr_accept = wr_req && en_q && !full;

  always_comb begin
    en_d  = en_q;
    ovf_d = ovf_hit;
    if (ovf_hit)             en_d = 1'b0;
    else if (!en_q && flag_seen) en_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b1;
      ovf_q <= 1'b0;
    end else begin
      en_q  <= en_d;
      ovf_q <= ovf_d;
    end
  end

  assign rx_enabled   = en_q;
  assign overflow_evt = ovf_q;
endmodule

// File: rtl/hdlc_rx_fifo_ctrl.sv
module hdlc_rx_fifo_ctrl #(
  parameter int DEPTH = 128,
  localparam int AW = $clog2(DEPTH),
  localparam int LW = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          rd_en,
  output logic [AW-1:0] wptr,
  output logic [AW-1:0] rptr,
  output logic [LW-1:0] level,
  output logic          empty,
  output logic          full,
  output logic          empty_rd_evt
);
  logic [AW-1:0] wptr_d, rptr_d;
  logic [LW-1:0] lvl_d;
  logic          erd_d, erd_q, pop;

  assign empty = (level == '0);
  assign full  = (level == LW'(DEPTH));
  assign pop   = rd_en && !empty;

  always_comb begin
    wptr_d = wptr;
    rptr_d = rptr;
    lvl_d  = level;
    erd_d  = rd_en && empty;
    if (push) wptr_d = (wptr == AW'(DEPTH-1)) ? '0 : wptr + 1'b1;
    if (pop)  rptr_d = (rptr == AW'(DEPTH-1)) ? '0 : rptr + 1'b1;
    if (push && !pop)      lvl_d = level + 1'b1;
    else if (pop && !push) lvl_d = level - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      level <= '0;
      erd_q <= 1'b0;
    end else begin
      wptr  <= wptr_d;
      rptr  <= rptr_d;
      level <= lvl_d;
      erd_q <= erd_d;
    end
  end

  assign empty_rd_evt = erd_q;
endmodule

// File: rtl/hdlc_rx_fifo.sv
module hdlc_rx_fifo
  import hdlc_rx_fifo_pkg::*;
#(
  parameter int DEPTH = 128,
  parameter int SYNC_STAGES = 2,
  localparam int AW = $clog2(DEPTH),
  localparam int LW = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [7:0]    wr_data,
  input  logic [1:0]    wr_tag,
  input  logic          flag_seen,
  input  logic          rd_en,
  input  logic [AW-1:0] full_thresh,
  output logic [7:0]    rd_data,
  output logic [1:0]    rd_tag,
  output logic [LW-1:0] level,
  output logic          above_thresh,
  output logic          last_next,
  output logic          rx_enabled,
  output logic          overflow_evt,
  output logic          empty_rd_evt
);
  logic [SYNC_STAGES-1:0] rst_pipe;
  logic                   rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_core_n = rst_pipe[SYNC_STAGES-1];

  logic          push, empty, full;
  logic [AW-1:0] wptr, rptr;
  fifo_entry_t   wentry, rentry;

  assign wentry.data = wr_data;
  assign wentry.tag  = eop_tag_e'(wr_tag);

  hdlc_rx_ovf_lock u_lock (
    .clk          (clk),
    .rst_n        (rst_core_n),
    .wr_req       (wr_en),
    .full         (full),
    .flag_seen    (flag_seen),
    .wr_accept    (push),
    .rx_enabled   (rx_enabled),
    .overflow_evt (overflow_evt)
  );

  hdlc_rx_fifo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_core_n),
    .push         (push),
    .rd_en        (rd_en),
    .wptr         (wptr),
    .rptr         (rptr),
    .level        (level),
    .empty        (empty),
    .full         (full),
    .empty_rd_evt (empty_rd_evt)
  );

  hdlc_rx_fifo_mem #(.DEPTH(DEPTH)) u_mem (
    .clk    (clk),
    .we     (push),
    .waddr  (wptr),
    .wentry (wentry),
    .raddr  (rptr),
    .rentry (rentry)
  );

  assign rd_data      = empty ? 8'h00 : rentry.data;
  assign rd_tag       = empty ? 2'd0 : rentry.tag;
  assign last_next    = !empty && (rentry.tag != TAG_MID);
  assign above_thresh = level > LW'(full_thresh);
endmodule

// File: rtl/hdlc_rx_fifo_chk.sv
module hdlc_rx_fifo_chk #(
  parameter int DEPTH = 128,
  localparam int LW = $clog2(DEPTH) + 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic          rd_en,
  input logic          flag_seen,
  input logic [LW-1:0] level,
  input logic [7:0]    rd_data,
  input logic          last_next,
  input logic          rx_enabled,
  input logic          overflow_evt,
  input logic          empty_rd_evt
);
  // R5
  level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    level <= LW'(DEPTH));

  // R7
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && rx_enabled && level == LW'(DEPTH)) |=> (overflow_evt && !rx_enabled));

  // R8
  locked_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !rx_enabled && !rd_en) |=> (level == $past(level) && !overflow_evt));

  // R9
  flag_reenable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_enabled && flag_seen) |=> rx_enabled);

  // R10
  empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && level == '0) |=> empty_rd_evt);

  // R4
  empty_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (level == '0) |-> (!last_next && rd_data == 8'h00));
endmodule

bind hdlc_rx_fifo hdlc_rx_fifo_chk #(.DEPTH(DEPTH)) u_chk (
  .clk          (clk),
  .rst_n        (rst_core_n),
  .wr_en        (wr_en),
  .rd_en        (rd_en),
  .flag_seen    (flag_seen),
  .level        (level),
  .rd_data      (rd_data),
  .last_next    (last_next),
  .rx_enabled   (rx_enabled),
  .overflow_evt (overflow_evt),
  .empty_rd_evt (empty_rd_evt)
);

// File: tb/tb_hdlc_rx_fifo.sv
module tb_hdlc_rx_fifo;
  localparam int DEPTH = 128;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0, flag_seen = 1'b0, rd_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [1:0] wr_tag = '0;
  logic [6:0] full_thresh = 7'd10;
  logic [7:0] rd_data, level;
  logic [1:0] rd_tag;
  logic       above_thresh, last_next, rx_enabled, overflow_evt, empty_rd_evt;

  int n_chk = 0, n_fail = 0;
  logic [9:0] model [$];

  always #2.5 clk = ~clk;

  hdlc_rx_fifo dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .wr_tag(wr_tag),
    .flag_seen(flag_seen), .rd_en(rd_en), .full_thresh(full_thresh),
    .rd_data(rd_data), .rd_tag(rd_tag), .level(level), .above_thresh(above_thresh),
    .last_next(last_next), .rx_enabled(rx_enabled), .overflow_evt(overflow_evt),
    .empty_rd_evt(empty_rd_evt)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cycle();
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0; flag_seen = 1'b0;
  endtask

  task automatic push(input logic [7:0] d, input logic [1:0] t);
    wr_en = 1'b1; wr_data = d; wr_tag = t;
    if (rx_enabled && level != DEPTH) model.push_back({t, d});
    cycle();
  endtask

  task automatic pop_check(input string req);
    logic [9:0] e;
    e = model.pop_front();
    check(req, {6'd0, rd_tag, rd_data}, {6'd0, e});
    check("R4", {15'd0, last_next}, {15'd0, e[9:8] != 2'd0});
    rd_en = 1'b1;
    cycle();
  endtask

  task automatic t_reset();
    check("R1 level", {8'd0, level}, 16'd0);
    check("R1 rx_enabled", {15'd0, rx_enabled}, 16'd1);
    check("R1 flags", {12'd0, last_next, above_thresh, overflow_evt, empty_rd_evt}, 16'd0);
    check("R1 rd", {6'd0, rd_tag, rd_data}, 16'd0);
  endtask

  task automatic t_order();
    push(8'hA1, 2'd0);
    check("R2 show-ahead", {8'd0, rd_data}, 16'h00A1);
    push(8'hB2, 2'd1);
    push(8'hC3, 2'd0);
    push(8'hD4, 2'd2);
    push(8'hE5, 2'd3);
    check("R5 level", {8'd0, level}, 16'd5);
    for (int i = 0; i < 5; i++) pop_check("R3 R2 order/tag");
    check("R5 drained", {8'd0, level}, 16'd0);
  endtask

  task automatic t_simul();
    push(8'h11, 2'd0);
    push(8'h22, 2'd1);
    wr_en = 1'b1; wr_data = 8'h33; wr_tag = 2'd0; rd_en = 1'b1;
    model.push_back({2'd0, 8'h33});
    void'(model.pop_front());
    cycle();
    check("R5 simul rw", {8'd0, level}, 16'd2);
    pop_check("R2 after simul");
    pop_check("R2 after simul");
  endtask

  task automatic t_thresh();
    full_thresh = 7'd3;
    for (int i = 0; i < 3; i++) push(8'(i), 2'd0);
    check("R6 at threshold", {15'd0, above_thresh}, 16'd0);
    push(8'h40, 2'd1);
    check("R6 above threshold", {15'd0, above_thresh}, 16'd1);
    for (int i = 0; i < 4; i++) pop_check("R2 thresh drain");
    full_thresh = 7'd0;
    push(8'h41, 2'd0);
    check("R6 zero threshold", {15'd0, above_thresh}, 16'd1);
    pop_check("R2 drain");
    full_thresh = 7'd127;
  endtask

  task automatic t_empty_read();
    rd_en = 1'b1;
    cycle();
    check("R10 evt", {15'd0, empty_rd_evt}, 16'd1);
    check("R10 data", {6'd0, rd_tag, rd_data}, 16'd0);
    check("R10 level", {8'd0, level}, 16'd0);
    cycle();
    check("R10 evt falls", {15'd0, empty_rd_evt}, 16'd0);
    push(8'h5C, 2'd1);
    pop_check("R10 pointer unchanged");
  endtask

  task automatic t_overflow();
    for (int i = 0; i < DEPTH; i++) push(8'(i ^ 8'h5A), (i == DEPTH-1) ? 2'd1 : 2'd0);
    check("R5 full level", {8'd0, level}, 16'd128);
    check("R6 127 thresh", {15'd0, above_thresh}, 16'd1);
    check("R7 no evt yet", {15'd0, overflow_evt}, 16'd0);
    wr_en = 1'b1; wr_data = 8'hEE; wr_tag = 2'd0;
    cycle();
    check("R7 evt", {15'd0, overflow_evt}, 16'd1);
    check("R7 disabled", {15'd0, rx_enabled}, 16'd0);
    check("R7 level", {8'd0, level}, 16'd128);
    cycle();
    check("R7 evt one cycle", {15'd0, overflow_evt}, 16'd0);
    pop_check("R7 head intact");
    wr_en = 1'b1; wr_data = 8'hEF;
    cycle();
    check("R8 locked write", {8'd0, level}, 16'd127);
    check("R8 no evt", {15'd0, overflow_evt}, 16'd0);
    push(8'h01, 2'd0);
    check("R8 still locked", {8'd0, level}, 16'd127);
    flag_seen = 1'b1;
    cycle();
    check("R9 reenabled", {15'd0, rx_enabled}, 16'd1);
    push(8'h77, 2'd2);
    check("R9 accepted", {8'd0, level}, 16'd128);
    wr_en = 1'b1; wr_data = 8'hEE; rd_en = 1'b1;
    void'(model.pop_front());
    cycle();
    check("R9 R7 overflow again with read", {14'd0, overflow_evt, rx_enabled}, 16'd2);
    check("R7 read popped", {8'd0, level}, 16'd127);
    while (model.size() > 0) pop_check("R2 full drain");
    check("R5 empty end", {8'd0, level}, 16'd0);
    flag_seen = 1'b1;
    cycle();
  endtask

  initial begin
    fork
      begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
      end
    join_none
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_order();
    t_simul();
    t_thresh();
    t_empty_read();
    t_overflow();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule